// File: doc/BRIEF.md
# 64-bit Iterative Integer Multiplier

This block is the multiply datapath of a 64-bit integer core. It takes two 64-bit source operands, a 3-bit operation code and a word-mode flag. From these it produces one 64-bit result. The result is either the lower or the upper half of the full 128-bit product. Three signedness pairings are supported for the upper half. In word mode, the low 32 bits of each operand are multiplied and the 32-bit result is sign-extended to 64 bits. Instruction decode, the register file and hazard tracking belong to the surrounding pipeline.

A one-cycle `start_i` pulse while the unit is idle captures the operands and the operation. The datapath multiplies the operand magnitudes with a shift-add loop that retires `STEP` multiplier bits per cycle. It applies the sign of the product on the final iteration. It then raises `done_o` for one cycle, with the result on `result_o`. Unsupported operation codes do not start the loop. They finish one cycle after acceptance, with `illegal_o` set and a zero result.

The controller has three states:
- `ST_IDLE` waits for `start_i`.
- `ST_RUN` iterates `XLEN/STEP` times.
- `ST_FIN` presents the result.

The transitions are:
- accept-legal: `ST_IDLE`→`ST_RUN`.
- accept-illegal: `ST_IDLE`→`ST_FIN`.
- last-iteration: `ST_RUN`→`ST_FIN`.
- retire: `ST_FIN`→`ST_IDLE`.
- reset: any state→`ST_IDLE`.

Top module: `mul64_unit`

## Requirements
- R1: With word mode off and `op_i` = 3'b000, the result is bits 63:0 of the product of the two operands.
- R2: With word mode off and `op_i` = 3'b001, both operands are signed and the result is bits 127:64 of the 128-bit product.
- R3: With word mode off and `op_i` = 3'b010, the first operand is signed and the second is unsigned, and the result is bits 127:64 of the product.
- R4: With word mode off and `op_i` = 3'b011, both operands are unsigned and the result is bits 127:64 of the product.
- R5: With word mode on and `op_i` = 3'b000, only bits 31:0 of each operand take part. The result is bits 31:0 of their product with bit 31 copied into bits 63:32, so the upper operand bits have no effect on the result.
- R6: An operation is illegal when word mode is on with `op_i` ≠ 3'b000, or when `op_i[2]` = 1. An illegal operation raises `done_o` and `illegal_o` together in the cycle after acceptance, with `result_o` = 0. `illegal_o` is never high on a legal operation.
- R7: After a legal start is accepted at a clock edge, `done_o` is high for exactly one cycle, starting `XLEN/STEP` edges later (16 edges at the defaults). `result_o` is valid while `done_o` is high and zero otherwise.
- R8: `busy_o` is high from acceptance through the done cycle. A `start_i` seen while `busy_o` is high is ignored and does not change the result in progress.
- R9: When `rst_n` is low at a clock edge (synchronous, active low), `busy_o` and `done_o` are low after that edge. This also abandons an operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| op_i | input | 3 | Operation code |
| word_i | input | 1 | Word (32-bit) mode flag |
| rs1_i | input | XLEN | First operand |
| rs2_i | input | XLEN | Second operand |
| busy_o | output | 1 | Operation accepted and not yet retired |
| done_o | output | 1 | One-cycle result strobe |
| illegal_o | output | 1 | Operation code rejected (with done_o) |
| result_o | output | XLEN | Result, valid with done_o |

## Verification
The assertions check the handshake on every cycle:
- the one-cycle done strobe and the exact latency from acceptance;
- busy holding until done;
- the illegal flag appearing only for rejected codes;
- the sign extension of word-mode results;
- idle outputs after reset.

Only the bench's scenarios can show bit-exact product halves, which it compares against a 128-bit reference. These scenarios cover the most-negative and all-ones operand pairings, zero operands, word operands with noisy upper bits, starts issued while busy, and a reset that abandons an operation midway.

// File: rtl/mul64_pkg.sv
package mul64_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } mul_state_e;

    localparam logic [2:0] F3_LO     = 3'b000;
    localparam logic [2:0] F3_HI_SS  = 3'b001;
    localparam logic [2:0] F3_HI_SU  = 3'b010;
    localparam logic [2:0] F3_HI_UU  = 3'b011;

    typedef struct packed {
        logic sgn_a;
        logic sgn_b;
        logic hi_half;
        logic word;
        logic bad;
    } mul_ctl_t;

endpackage

// File: rtl/mul64_opdec.sv
module mul64_opdec
    import mul64_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic       word_i,
    output mul_ctl_t   ctl_o
);

    always_comb begin
        ctl_o      = '0;
        ctl_o.word = word_i;
        case (op_i)
            F3_LO: begin
                ctl_o.hi_half = 1'b0;
            end
            F3_HI_SS: begin
                ctl_o.sgn_a   = 1'b1;
                ctl_o.sgn_b   = 1'b1;
                ctl_o.hi_half = 1'b1;
                ctl_o.bad     = word_i;
            end
            F3_HI_SU: begin
                ctl_o.sgn_a   = 1'b1;
                ctl_o.hi_half = 1'b1;
                ctl_o.bad     = word_i;
            end
            F3_HI_UU: begin
                ctl_o.hi_half = 1'b1;
                ctl_o.bad     = word_i;
            end
            default: begin
                ctl_o.bad = 1'b1;
            end
        endcase
        if (word_i) begin
            ctl_o.sgn_a = 1'b0;
            ctl_o.sgn_b = 1'b0;
        end
    end

endmodule

// File: rtl/mul64_iter.sv
module mul64_iter #(
    parameter int XLEN = 64,
    parameter int STEP = 4
) (
    input  logic              clk,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              last_i,
    input  logic [XLEN-1:0]   mcand_i,
    input  logic [XLEN-1:0]   mplier_i,
    input  logic              neg_i,
    output logic [2*XLEN-1:0] prod_o
);

    localparam int PW = 2 * XLEN;
    localparam int AW = XLEN + STEP;

    logic [PW-1:0]      prod_q;
    logic [XLEN-1:0]    mcand_q;
    logic               neg_q;
    logic [AW-1:0]      pp [STEP];
    logic [AW-1:0]      acc;
    logic [PW+STEP-1:0] wide;
    logic [PW-1:0]      shifted;
    logic [PW-1:0]      nxt;

    genvar g;
    generate
        for (g = 0; g < STEP; g++) begin : g_pp
            assign pp[g] = prod_q[g] ? ({{STEP{1'b0}}, mcand_q} << g) : '0;
        end
    endgenerate

    always_comb begin
        acc = {{STEP{1'b0}}, prod_q[PW-1:XLEN]};
        for (int k = 0; k < STEP; k++) begin
            acc = acc + pp[k];
        end
        wide    = {acc, prod_q[XLEN-1:0]};
        shifted = wide[PW+STEP-1:STEP];
        nxt     = (last_i && neg_q) ? (~shifted + 1'b1) : shifted;
    end

    always_ff @(posedge clk) begin
        if (load_i) begin
            prod_q  <= {{XLEN{1'b0}}, mplier_i};
            mcand_q <= mcand_i;
            neg_q   <= neg_i;
        end else if (step_i) begin
            prod_q  <= nxt;
        end
    end

    assign prod_o = prod_q;

endmodule

// File: rtl/mul64_ctrl.sv
module mul64_ctrl
    import mul64_pkg::*;
#(
    parameter int NITER = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic bad_i,
    input  logic hi_i,
    input  logic word_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o,
    output logic bad_q_o,
    output logic hi_q_o,
    output logic word_q_o
);

    localparam int CW = (NITER > 1) ? $clog2(NITER) : 1;

    mul_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == CW'(NITER - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = bad_i ? ST_FIN : ST_RUN;
            ST_RUN:  if (at_last) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            bad_q_o  <= 1'b0;
            hi_q_o   <= 1'b0;
            word_q_o <= 1'b0;
        end else if (state_q == ST_IDLE && start_i) begin
            cnt_q    <= '0;
            bad_q_o  <= bad_i;
            hi_q_o   <= hi_i;
            word_q_o <= word_i;
        end else if (state_q == ST_RUN) begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        last_o = 1'b0;
        busy_o = 1'b1;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load_o = start_i && !bad_i;
            end
            ST_RUN: begin
                step_o = 1'b1;
                last_o = at_last;
            end
            ST_FIN: begin
                done_o = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/mul64_unit.sv
module mul64_unit
    import mul64_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [2:0]      op_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] rs1_i,
    input  logic [XLEN-1:0] rs2_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            illegal_o,
    output logic [XLEN-1:0] result_o
);

    localparam int HALF  = XLEN / 2;
    localparam int PW    = 2 * XLEN;
    localparam int NITER = XLEN / STEP;

    mul_ctl_t        ctl;
    logic [XLEN-1:0] a_sel, b_sel, mag_a, mag_b;
    logic            neg_a, neg_b;
    logic            load, step, last, bad_q, hi_q, word_q;
    logic [PW-1:0]   prod;

    mul64_opdec u_dec (
        .op_i   (op_i),
        .word_i (word_i),
        .ctl_o  (ctl)
    );

    always_comb begin
        a_sel = ctl.word ? {{HALF{1'b0}}, rs1_i[HALF-1:0]} : rs1_i;
        b_sel = ctl.word ? {{HALF{1'b0}}, rs2_i[HALF-1:0]} : rs2_i;
        neg_a = ctl.sgn_a && rs1_i[XLEN-1];
        neg_b = ctl.sgn_b && rs2_i[XLEN-1];
        mag_a = neg_a ? (~rs1_i + 1'b1) : a_sel;
        mag_b = neg_b ? (~rs2_i + 1'b1) : b_sel;
    end

    mul64_ctrl #(.NITER(NITER)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .bad_i    (ctl.bad),
        .hi_i     (ctl.hi_half),
        .word_i   (ctl.word),
        .load_o   (load),
        .step_o   (step),
        .last_o   (last),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .bad_q_o  (bad_q),
        .hi_q_o   (hi_q),
        .word_q_o (word_q)
    );

    mul64_iter #(.XLEN(XLEN), .STEP(STEP)) u_iter (
        .clk      (clk),
        .load_i   (load),
        .step_i   (step),
        .last_i   (last),
        .mcand_i  (mag_a),
        .mplier_i (mag_b),
        .neg_i    (neg_a ^ neg_b),
        .prod_o   (prod)
    );

    assign illegal_o = done_o && bad_q;

    always_comb begin
        result_o = '0;
        if (done_o && !bad_q) begin
            if (word_q)    result_o = {{HALF{prod[HALF-1]}}, prod[HALF-1:0]};
            else if (hi_q) result_o = prod[PW-1:XLEN];
            else           result_o = prod[XLEN-1:0];
        end
    end

endmodule

// File: rtl/mul64_unit_chk.sv
module mul64_unit_chk #(
    parameter int XLEN = 64,
    parameter int STEP = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [2:0]      op_i,
    input logic            word_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            illegal_o,
    input logic [XLEN-1:0] result_o
);

    localparam int HALF  = XLEN / 2;
    localparam int NITER = XLEN / STEP;

    logic [15:0] run_cnt;
    logic        bad_q, word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            bad_q   <= 1'b0;
            word_q  <= 1'b0;
        end else if (start_i && !busy_o) begin
            run_cnt <= '0;
            bad_q   <= (word_i && op_i != 3'b000) || op_i[2];
            word_q  <= word_i;
        end else if (busy_o && !done_o) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !illegal_o) |-> (run_cnt == 16'(NITER)));

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    assert_illegal_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && bad_q && result_o == '0));

    assert_legal_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !bad_q) |-> !illegal_o);

    assert_word_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !illegal_o && word_q) |-> (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}}));

endmodule

bind mul64_unit mul64_unit_chk #(.XLEN(XLEN), .STEP(STEP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_i      (op_i),
    .word_i    (word_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .illegal_o (illegal_o),
    .result_o  (result_o)
);

// File: tb/tb_mul64_unit.sv
`timescale 1ns/1ps
module tb_mul64_unit;

    localparam int LAT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = 3'b000;
    logic        word_i = 1'b0;
    logic [63:0] rs1_i = '0;
    logic [63:0] rs2_i = '0;
    logic        busy_o, done_o, illegal_o;
    logic [63:0] result_o;

    int n_chk = 0;
    int n_fail = 0;

    int          m_cnt = 0;
    bit          m_fin = 1'b0;
    logic [63:0] exp_res = '0;
    bit          exp_ill = 1'b0;
    string       exp_tag = "R1";

    always #2 clk = ~clk;

    mul64_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .word_i(word_i),
        .rs1_i(rs1_i), .rs2_i(rs2_i), .busy_o(busy_o), .done_o(done_o),
        .illegal_o(illegal_o), .result_o(result_o)
    );

    function automatic void ref_calc(input logic [63:0] a, input logic [63:0] b,
                                     input logic [2:0] op, input logic w,
                                     output logic [63:0] r, output bit ill, output string tag);
        logic [127:0] ea, eb, p;
        ill = (w && op != 3'b000) || op[2];
        r   = '0;
        if (ill) begin
            tag = "R6";
        end else if (w) begin
            p   = {96'b0, a[31:0]} * {96'b0, b[31:0]};
            r   = {{32{p[31]}}, p[31:0]};
            tag = "R5";
        end else begin
            ea = (op == 3'd1 || op == 3'd2) ? {{64{a[63]}}, a} : {64'b0, a};
            eb = (op == 3'd1) ? {{64{b[63]}}, b} : {64'b0, b};
            p  = ea * eb;
            r  = (op == 3'd0) ? p[63:0] : p[127:64];
            case (op)
                3'd0:    tag = "R1";
                3'd1:    tag = "R2";
                3'd2:    tag = "R3";
                default: tag = "R4";
            endcase
        end
    endfunction

    // behavioural model of the handshake, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_fin = 1'b0;
        end else if (m_fin) begin
            m_fin = 1'b0;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) m_fin = 1'b1;
        end else if (start_i) begin
            ref_calc(rs1_i, rs2_i, op_i, word_i, exp_res, exp_ill, exp_tag);
            if (exp_ill) m_fin = 1'b1;
            else         m_cnt = LAT;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        bit eb;
        eb = (m_cnt > 0) || m_fin;
        n_chk++;
        if (busy_o !== eb || done_o !== m_fin) begin
            n_fail++;
            $display("FAIL R7/R8 handshake: busy=%b done=%b expected busy=%b done=%b",
                     busy_o, done_o, eb, m_fin);
        end
        if (m_fin) begin
            n_chk++;
            if (result_o !== exp_res || illegal_o !== exp_ill) begin
                n_fail++;
                $display("FAIL %s result: got %h ill=%b expected %h ill=%b",
                         exp_tag, result_o, illegal_o, exp_res, exp_ill);
            end
        end else if (done_o === 1'b0 && result_o !== 64'd0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 result outside done: got %h expected 0", result_o);
        end
    end

    task automatic wait_idle();
        while (m_cnt > 0 || m_fin) @(negedge clk);
    endtask

    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          input logic [2:0] op, input logic w);
        @(negedge clk);
        rs1_i = a; rs2_i = b; op_i = op; word_i = w; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
    endtask

    task automatic check_idle(input string tag);
        n_chk++;
        if (busy_o !== 1'b0 || done_o !== 1'b0) begin
            n_fail++;
            $display("FAIL %s idle: busy=%b done=%b expected 0 0", tag, busy_o, done_o);
        end
    endtask

    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_idle("R9");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R9");

        // corner pairs over all four full-width codes (R1..R4)
        for (int op = 0; op < 4; op++) begin
            run_op(MINV, MINV, 3'(op), 1'b0);
            run_op(MINV, ONES, 3'(op), 1'b0);
            run_op(ONES, MINV, 3'(op), 1'b0);
            run_op(64'd0, ONES, 3'(op), 1'b0);
            run_op(MINV, 64'd0, 3'(op), 1'b0);
            run_op(ONES, ONES, 3'(op), 1'b0);
            run_op(MAXV, MAXV, 3'(op), 1'b0);
            run_op(64'd1, MINV, 3'(op), 1'b0);
            run_op(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 3'(op), 1'b0);
        end

        // word mode, upper bits noisy (R5)
        run_op(64'hDEAD_BEEF_8000_0000, 64'h1234_5678_8000_0000, 3'd0, 1'b1);
        run_op(64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0000_0000_0002, 3'd0, 1'b1);
        run_op(64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_FFFF_FFFF, 3'd0, 1'b1);
        run_op(64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_1234_5678, 3'd0, 1'b1);
        run_op(64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000, 3'd0, 1'b1);

        // illegal codes (R6)
        for (int op = 1; op < 8; op++) run_op(ONES, ONES, 3'(op), 1'b1);
        for (int op = 4; op < 8; op++) run_op(ONES, MINV, 3'(op), 1'b0);
        run_op(64'd7, 64'd9, 3'd0, 1'b0);

        // start held high while busy must be ignored (R8)
        @(negedge clk);
        rs1_i = 64'h0000_0000_0000_0003; rs2_i = 64'h0000_0000_0000_0005;
        op_i = 3'd0; word_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        rs1_i = ONES; rs2_i = MINV; op_i = 3'd1;
        repeat (LAT + 1) begin
            n_chk++;
            if (busy_o !== 1'b1) begin
                n_fail++;
                $display("FAIL R8 busy during run: got %b expected 1", busy_o);
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        wait_idle();

        // reset abandons an operation in flight (R9)
        @(negedge clk);
        rs1_i = MAXV; rs2_i = MAXV; op_i = 3'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R9");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R9");

        // pseudo-random operands over all legal modes (R1..R5)
        for (int i = 0; i < 60; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (i % 5 == 4) run_op(a, b, 3'd0, 1'b1);
            else            run_op(a, b, 3'(i % 4), 1'b0);
        end

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule